// File: doc/BRIEF.md
# Paged Register I/O Port Bank

This block is a byte-wide register bank that controls 48 open-drain I/O lines, arranged as six 8-bit ports. Each line is controlled on its own. Writing a 1 to a port bit makes the pin sink current, which pulls it low. Writing a 0 releases the pin to high impedance, where an external pull-up holds it high, so the line can be used as an input. Reading a port returns the inverse of the synchronised pin level.

Lines 0 to 23 also carry edge-detection settings. There are three polarity bytes, three enable bytes and three interrupt-ID bytes. They sit behind a paged window of three offsets, and a page/lock register selects which set the window shows. The edge detector is a separate block. It reads the polarity and enable bytes from this bank, receives the synchronised lower 24 lines, and sets ID bits through a set vector. Software clears ID bits by writing the ID bytes.

The host bus is synchronous. It has a 4-bit address, 8-bit write data, a write strobe and a read strobe. Read data is registered and appears on the clock edge that samples the read strobe.

Top module: `pagedIoBank`

## Requirements
- R1: A write to port offset p (0 to 5) loads byte p of the line-drive vector, so pinOe[8p+7:8p] equals the written byte from the next cycle on. A 1 means the line is pulled low. Reset clears all 48 drive bits.
- R2: A read of port offset p returns the bitwise inverse of pin byte p after a two-flop synchroniser. A pin change made just before edge k shows up in reads sampled on edge k+2 or later, and not in reads sampled on edge k or k+1. edgePins carries the synchronised, non-inverted lines 0 to 23.
- R3: Offset 7 is the page/lock register. It reads back the last byte written to it. Bits 7:6 select the page, and bits 5:0 are stored lock flags.
- R4: On page 1, offsets 8, 9 and 10 read and write polarity bytes 0, 1 and 2. Those bytes drive polOut[7:0], [15:8] and [23:16].
- R5: On page 2, offsets 8, 9 and 10 read and write enable bytes 0 to 2, which drive enOut in the same byte order.
- R6: On page 3, offsets 8, 9 and 10 access interrupt-ID bytes 0 to 2, which appear on intIdOut. A bit of edgeIdSet that is high sets the matching ID bit on the next edge. A write replaces the byte, except that a set arriving in the same cycle wins.
- R7: On page 0, offsets 8 to 10 read 0x00, and writes to them change no polarity, enable or ID bit.
- R8: Offset 6 reads the pending summary on every page. Bit i (i = 0 to 2) is the OR of ID byte i, and bits 7:3 read 0. Writes to offset 6 have no effect.
- R9: The port offsets 0 to 5 behave the same whatever page is selected.
- R10: Offsets 11 to 15 read 0x00 on every page.
- R11: Reset clears the page/lock register and all polarity, enable and ID bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data |
| pinIn | input | 48 | Pin levels |
| pinOe | output | 48 | Line pull-low enables, 1 = sink |
| edgeIdSet | input | 24 | Set requests for the interrupt-ID bits |
| polOut | output | 24 | Polarity bytes to the edge detector |
| enOut | output | 24 | Enable bytes to the edge detector |
| intIdOut | output | 24 | Interrupt-ID bytes |
| edgePins | output | 24 | Synchronised lines 0 to 23 |

## Verification
A page register that holds the wrong value sends accesses at offsets 8 to 10 to the wrong byte group. The same paged write then moves polOut or enOut when it should not, and this shows on those outputs one cycle after the write. A synchroniser with the wrong depth shows up as a port read that reflects a pin change one edge too early or too late, so reads are issued on consecutive edges straight after a pin change. A wrong ID or pending state shows up on intIdOut and on the offset-6 read on the cycle that follows the set or the clearing write.

// File: rtl/pagedIoPkg.sv
package pagedIoPkg;
  localparam int NUM_PORTS  = 6;
  localparam int PORT_W     = 8;
  localparam int EDGE_BYTES = 3;
  localparam int ADDR_W     = 4;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_PORT, SEL_PEND, SEL_PAGE, SEL_POL, SEL_EN, SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0]  portWr;
    logic                  pageWr;
    logic [EDGE_BYTES-1:0] polWr;
    logic [EDGE_BYTES-1:0] enWr;
    logic [EDGE_BYTES-1:0] idWr;
    logic                  rdEn;
    rdSel_e                rdSel;
    logic [2:0]            rdIdx;
  } ioStrobes_t;
endpackage

// File: rtl/ioCtrl.sv
module ioCtrl
  import pagedIoPkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        curPage,
  output ioStrobes_t        strb
);
  localparam logic [ADDR_W-1:0] PEND_ADDR  = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] PAGE_ADDR  = ADDR_W'(NUM_PORTS + 1);
  localparam logic [ADDR_W-1:0] PAGED_BASE = ADDR_W'(NUM_PORTS + 2);

  logic isPort;
  logic [ADDR_W-1:0] pagedOff;

  assign pagedOff = busAddr - PAGED_BASE;

  always_comb begin
    strb       = '0;
    strb.rdEn  = busRd;
    strb.rdSel = SEL_ZERO;
    isPort     = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (busAddr == ADDR_W'(i)) begin
        strb.portWr[i] = busWr;
        isPort = 1'b1;
      end
    end
    if (isPort) begin
      strb.rdSel = SEL_PORT;
      strb.rdIdx = busAddr[2:0];
    end else if (busAddr == PEND_ADDR) begin
      strb.rdSel = SEL_PEND;
    end else if (busAddr == PAGE_ADDR) begin
      strb.pageWr = busWr;
      strb.rdSel  = SEL_PAGE;
    end else begin
      for (int b = 0; b < EDGE_BYTES; b++) begin
        if (busAddr >= PAGED_BASE && pagedOff == ADDR_W'(b)) begin
          strb.rdIdx = 3'(b);
          unique case (curPage)
            2'd1: begin strb.polWr[b] = busWr; strb.rdSel = SEL_POL; end
            2'd2: begin strb.enWr[b]  = busWr; strb.rdSel = SEL_EN;  end
            2'd3: begin strb.idWr[b]  = busWr; strb.rdSel = SEL_ID;  end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ioDatapath.sv
module ioDatapath
  import pagedIoPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LINES  = NUM_PORTS * PORT_W,
  localparam int EDGE_LINES = EDGE_BYTES * PORT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ioStrobes_t            strb,
  input  logic [PORT_W-1:0]     busWrData,
  output logic [PORT_W-1:0]     busRdData,
  input  logic [NUM_LINES-1:0]  pinIn,
  output logic [NUM_LINES-1:0]  pinOe,
  input  logic [EDGE_LINES-1:0] edgeIdSet,
  output logic [EDGE_LINES-1:0] polOut,
  output logic [EDGE_LINES-1:0] enOut,
  output logic [EDGE_LINES-1:0] intIdOut,
  output logic [EDGE_LINES-1:0] edgePins,
  output logic [1:0]            curPage
);
  logic [NUM_PORTS-1:0][PORT_W-1:0]  portLat;
  logic [EDGE_BYTES-1:0][PORT_W-1:0] polReg, enReg, idReg, idSetB;
  logic [PORT_W-1:0]                 pageLock;
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncChain;
  logic [NUM_PORTS-1:0][PORT_W-1:0]  pinSync;
  logic [PORT_W-1:0]                 pendByte;
  logic [PORT_W-1:0]                 rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end
  assign pinSync  = syncChain[SYNC_STAGES-1];
  assign edgePins = syncChain[SYNC_STAGES-1][EDGE_LINES-1:0];

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : gPort
      always_ff @(posedge clk) begin
        if (!rstN)              portLat[p] <= '0;
        else if (strb.portWr[p]) portLat[p] <= busWrData;
      end
    end
    for (p = 0; p < EDGE_BYTES; p++) begin : gEdge
      assign idSetB[p] = edgeIdSet[p*PORT_W +: PORT_W];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          polReg[p] <= '0;
          enReg[p]  <= '0;
          idReg[p]  <= '0;
        end else begin
          if (strb.polWr[p]) polReg[p] <= busWrData;
          if (strb.enWr[p])  enReg[p]  <= busWrData;
          idReg[p] <= (strb.idWr[p] ? busWrData : idReg[p]) | idSetB[p];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            pageLock <= '0;
    else if (strb.pageWr) pageLock <= busWrData;
  end

  assign curPage  = pageLock[PORT_W-1 -: 2];
  assign pinOe    = portLat;
  assign polOut   = polReg;
  assign enOut    = enReg;
  assign intIdOut = idReg;

  always_comb begin
    pendByte = '0;
    for (int b = 0; b < EDGE_BYTES; b++) pendByte[b] = |idReg[b];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_PORT: rdNext = ~pinSync[strb.rdIdx];
      SEL_PEND: rdNext = pendByte;
      SEL_PAGE: rdNext = pageLock;
      SEL_POL:  rdNext = polReg[strb.rdIdx];
      SEL_EN:   rdNext = enReg[strb.rdIdx];
      SEL_ID:   rdNext = idReg[strb.rdIdx];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdData <= '0;
    else if (strb.rdEn) busRdData <= rdNext;
  end
endmodule

// File: rtl/pagedIoBank.sv
module pagedIoBank
  import pagedIoPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LINES  = NUM_PORTS * PORT_W,
  localparam int EDGE_LINES = EDGE_BYTES * PORT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [PORT_W-1:0]     busWrData,
  input  logic                  busWr,
  input  logic                  busRd,
  output logic [PORT_W-1:0]     busRdData,
  input  logic [NUM_LINES-1:0]  pinIn,
  output logic [NUM_LINES-1:0]  pinOe,
  input  logic [EDGE_LINES-1:0] edgeIdSet,
  output logic [EDGE_LINES-1:0] polOut,
  output logic [EDGE_LINES-1:0] enOut,
  output logic [EDGE_LINES-1:0] intIdOut,
  output logic [EDGE_LINES-1:0] edgePins
);
  ioStrobes_t strb;
  logic [1:0] curPage;

  ioCtrl u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .curPage(curPage), .strb(strb)
  );

  ioDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOe(pinOe),
    .edgeIdSet(edgeIdSet), .polOut(polOut), .enOut(enOut),
    .intIdOut(intIdOut), .edgePins(edgePins), .curPage(curPage)
  );
endmodule

// File: rtl/pagedIoBank_chk.sv
module pagedIoBank_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  busAddr,
  input logic [7:0]  busWrData,
  input logic        busWr,
  input logic        busRd,
  input logic [7:0]  busRdData,
  input logic [7:0]  pinOeLow,
  input logic [23:0] edgeIdSet,
  input logic [23:0] polOut,
  input logic [23:0] intIdOut
);
  p_port_wr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'd0) |=> (pinOeLow == $past(busWrData)));

  p_page_readback_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'd7) ##1 (busRd && busAddr == 4'd7)
      |=> (busRdData == $past(busWrData, 2)));

  p_id_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((intIdOut & $past(edgeIdSet)) == $past(edgeIdSet)));

  p_pol_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr >= 4'd8 && busAddr <= 4'd10) |=> $stable(polOut));

  p_pend_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 4'd6) |=> (busRdData[7:3] == 5'd0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr >= 4'd11) |=> (busRdData == 8'h00));
endmodule

bind pagedIoBank pagedIoBank_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
  .pinOeLow(pinOe[7:0]), .edgeIdSet(edgeIdSet), .polOut(polOut),
  .intIdOut(intIdOut)
);

// File: tb/pagedIoBank_tb.sv
module pagedIoBank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [47:0] pinIn = '1;
  logic [47:0] pinOe;
  logic [23:0] edgeIdSet = '0;
  logic [23:0] polOut, enOut, intIdOut, edgePins;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  pagedIoBank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .pinIn(pinIn),
    .pinOe(pinOe), .edgeIdSet(edgeIdSet), .polOut(polOut), .enOut(enOut),
    .intIdOut(intIdOut), .edgePins(edgePins)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drivers: called right after a falling edge, return after the next one
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // monitor: pops one expected byte per sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (busRd && rstN) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL unexpected read: actual %h expected none", busRdData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(t, {40'd0, busRdData}, {40'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 reset drive", pinOe, 48'd0);
    chk("R11 reset pol", {24'd0, polOut}, 48'd0);
    chk("R11 reset en", {24'd0, enOut}, 48'd0);
    chk("R11 reset id", {24'd0, intIdOut}, 48'd0);
    rd(4'd7, 8'h00, "R11 reset page");

    wr(4'd2, 8'hA5);
    chk("R1 port2 drive", pinOe, 48'h0000_00A5_0000);
    wr(4'd5, 8'h3C);
    chk("R1 port5 drive", pinOe, 48'h3C00_00A5_0000);

    rd(4'd0, 8'h00, "R2 high pins read 0");
    pinIn[15:8] = 8'h0F;
    rd(4'd1, 8'h00, "R2 edge k old");
    rd(4'd1, 8'h00, "R2 edge k+1 old");
    rd(4'd1, 8'hF0, "R2 edge k+2 new");
    chk("R2 edgePins", {24'd0, edgePins}, {24'd0, 24'hFF0FFF});

    wr(4'd7, 8'h55);
    rd(4'd7, 8'h55, "R3 page/lock readback");

    wr(4'd7, 8'h40);
    wr(4'd8, 8'h11); wr(4'd9, 8'h22); wr(4'd10, 8'h33);
    chk("R4 polOut", {24'd0, polOut}, {24'd0, 24'h332211});
    rd(4'd9, 8'h22, "R4 pol byte1 read");

    wr(4'd7, 8'h80);
    wr(4'd8, 8'h44); wr(4'd10, 8'h66);
    chk("R5 enOut", {24'd0, enOut}, {24'd0, 24'h660044});
    chk("R5 pol untouched", {24'd0, polOut}, {24'd0, 24'h332211});
    rd(4'd10, 8'h66, "R5 en byte2 read");

    wr(4'd7, 8'hC0);
    edgeIdSet = 24'h010200;
    @(negedge clk);
    edgeIdSet = '0;
    chk("R6 id set", {24'd0, intIdOut}, {24'd0, 24'h010200});
    rd(4'd9, 8'h02, "R6 id byte1 read");
    rd(4'd6, 8'h06, "R8 pending bytes 1,2");
    wr(4'd9, 8'h00);
    rd(4'd9, 8'h00, "R6 id clear");
    rd(4'd6, 8'h04, "R8 pending byte 2");
    edgeIdSet = 24'h000080;
    wr(4'd8, 8'h01);
    edgeIdSet = '0;
    rd(4'd8, 8'h81, "R6 set wins over write");

    wr(4'd7, 8'h00);
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    chk("R7 pol ignored", {24'd0, polOut}, {24'd0, 24'h332211});
    chk("R7 en ignored", {24'd0, enOut}, {24'd0, 24'h660044});
    chk("R7 id ignored", {24'd0, intIdOut}, {24'd0, 24'h010081});
    rd(4'd8, 8'h00, "R7 page0 read zero");
    rd(4'd6, 8'h05, "R8 pending on page 0");

    wr(4'd7, 8'hC0);
    wr(4'd0, 8'h81);
    chk("R9 port0 on page3", pinOe, 48'h3C00_00A5_0081);
    rd(4'd1, 8'hF0, "R9 port1 read on page3");
    wr(4'd6, 8'hFF);
    rd(4'd6, 8'h05, "R8 write ignored");
    chk("R8 id after pend write", {24'd0, intIdOut}, {24'd0, 24'h010081});

    rd(4'd11, 8'h00, "R10 offset 11");
    rd(4'd15, 8'h00, "R10 offset 15");

    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 second reset drive", pinOe, 48'd0);
    chk("R11 second reset pol", {24'd0, polOut}, 48'd0);
    chk("R11 second reset en", {24'd0, enOut}, 48'd0);
    chk("R11 second reset id", {24'd0, intIdOut}, 48'd0);
    rd(4'd7, 8'h00, "R11 second reset page");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule